// File: doc/BRIEF.md
# Cipher Engine Command Queue Front End

This block sits between a processor and a block-cipher engine. The processor pushes 32-bit command words into a five-entry queue; the block pulls them out in order, classifies each by the 6-bit opcode in bits [31:26], and collects the address word that some commands need. It then drives request/done handshakes toward three stubbed units: the cipher datapath (block runs), the memory-copy unit (moves between external memory and internal RAM), and the key-table loader (a single-cycle pulse).

Block runs and copies are issued and left outstanding, so the queue keeps draining. A command that needs a unit that is still busy waits at the head of the queue. A fence command waits until both units are idle, so software can order work behind it. Completions and errors land in sticky status bits that are cleared by writing ones. An enable mask selects which of those bits drive the level interrupt.

Top module: `cmdq_front`

## Requirements
- R1: After reset no request is active, the interrupt is low, the interrupt mask is zero, and the status word reads 0x200 (queue empty only).
- R2: Opcode 0x10 consumes exactly the next queued word and presents it on `run_addr_o`. No other action is taken.
- R3: Opcode 0x0E raises `run_req_o` and holds it until `run_done_i`. `run_blocks_o` equals bits [11:0] plus one, so a field of 0 means one block.
- R4: Opcode 0x22 takes its direction from bit 25 (1 = internal RAM to external memory) and its word count from bits [19:12]. The next queued word is the external address. `copy_req_o` is then held, with stable fields, until `copy_done_i`.
- R5: Opcode 0x15 gives one pulse on `tbl_load_o`, carrying bits [20:17] as the table id, bit 23 as the RAM select and bits [25:24] as the table select.
- R6: A table load waits at the queue head while a run or a copy is outstanding.
- R7: Opcode 0x11 is a fence. It and every later command wait until no run and no copy is outstanding.
- R8: Any other opcode sets status bit 4 and is discarded without raising any request.
- R9: A word written while five words are queued is discarded and sets status bit 5.
- R10: A completed run sets status bit 0 and a completed copy sets status bit 1. A status write (select 0) clears the sticky bits where the data has ones, and a write of 0xFF clears all of them.
- R11: A write with select 1 loads the interrupt mask; 0x33 enables all four sources. `irq_o` is high exactly while some sticky bit and its mask bit are both set.
- R12: Status bit 8 shows engine busy (run or copy outstanding, or an address word awaited), bit 9 shows queue empty, and bit 10 shows a copy outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Push a command word |
| cmd_data_i | input | 32 | Command word |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = status clear, 1 = interrupt mask |
| reg_wdata_i | input | 8 | Register write data |
| status_o | output | 11 | Sticky and live status bits |
| irq_o | output | 1 | Level interrupt |
| run_req_o | output | 1 | Block run request, held until done |
| run_blocks_o | output | 13 | Number of blocks in the run |
| run_addr_o | output | 32 | Input buffer address |
| run_done_i | input | 1 | Block run finished |
| copy_req_o | output | 1 | Copy request, held until done |
| copy_to_ext_o | output | 1 | Copy direction, 1 = to external memory |
| copy_words_o | output | 8 | Copy length in words |
| copy_addr_o | output | 32 | External address for the copy |
| copy_done_i | input | 1 | Copy finished |
| tbl_load_o | output | 1 | Key-table load pulse |
| tbl_id_o | output | 4 | Key-table id |
| tbl_vram_o | output | 1 | Internal RAM select |
| tbl_sel_o | output | 2 | Table select |

## Verification
If the decoder's state gets out of step with the word stream, address and command words swap roles. The symptom shows up at the ports within one or two cycles: a request with the wrong address or count, or a spurious bit 4. A stuck outstanding flag shows up as a table load or a fence that never drains, with bit 9 staying low. A queue count that is off by one shows up as a word lost or repeated when a fence releases a full queue. A wrong sticky or mask bit is seen on `irq_o` in the same cycle that the register write lands.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam logic [5:0] OP_RUN   = 6'h0E;
  localparam logic [5:0] OP_SETUP = 6'h10;
  localparam logic [5:0] OP_FENCE = 6'h11;
  localparam logic [5:0] OP_TABLE = 6'h15;
  localparam logic [5:0] OP_COPY  = 6'h22;

  localparam int ST_RUN   = 0;
  localparam int ST_COPY  = 1;
  localparam int ST_BADOP = 4;
  localparam int ST_OVF   = 5;
  localparam int ST_W     = 11;
  localparam logic [7:0] STICKY_IMPL = 8'h33;

  typedef enum logic [2:0] {K_RUN, K_SETUP, K_FENCE, K_TABLE, K_COPY, K_BAD} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_SETUP_ADDR, S_COPY_ADDR} seq_e;

  function automatic kind_e classify(input logic [5:0] op);
    case (op)
      OP_RUN:   return K_RUN;
      OP_SETUP: return K_SETUP;
      OP_FENCE: return K_FENCE;
      OP_TABLE: return K_TABLE;
      OP_COPY:  return K_COPY;
      default:  return K_BAD;
    endcase
  endfunction
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          full, accept, take;

  assign full    = (cnt == FULL_CNT);
  assign empty_o = (cnt == '0);
  assign accept  = push_i && !full;
  assign take    = pop_i && !empty_o;
  assign drop_o  = push_i && full;
  assign head_o  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (accept) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (accept) wr_ptr <= bump(wr_ptr);
      if (take)   rd_ptr <= bump(rd_ptr);
      case ({accept, take})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cq_sequencer.sv
module cq_sequencer
  import cq_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int WC_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      head_i,
  input  logic             avail_i,
  output logic             pop_o,
  input  logic             run_done_i,
  input  logic             copy_done_i,
  output logic             run_req_o,
  output logic [CNT_W:0]   run_blocks_o,
  output logic [31:0]      run_addr_o,
  output logic             copy_req_o,
  output logic             copy_to_ext_o,
  output logic [WC_W-1:0]  copy_words_o,
  output logic [31:0]      copy_addr_o,
  output logic             tbl_load_o,
  output logic [3:0]       tbl_id_o,
  output logic             tbl_vram_o,
  output logic [1:0]       tbl_sel_o,
  output logic             busy_o,
  output logic             ev_run_o,
  output logic             ev_copy_o,
  output logic             ev_bad_o
);
  seq_e  state;
  kind_e kind;
  logic  run_busy, copy_busy;
  logic  go_run, go_setup, go_table, go_copy, bad, addr_setup, addr_copy;

  assign kind = classify(head_i[31:26]);

  always_comb begin
    pop_o = 1'b0; go_run = 1'b0; go_setup = 1'b0; go_table = 1'b0;
    go_copy = 1'b0; bad = 1'b0; addr_setup = 1'b0; addr_copy = 1'b0;
    if (avail_i) begin
      case (state)
        S_IDLE: begin
          case (kind)
            K_SETUP: begin pop_o = 1'b1; go_setup = 1'b1; end
            K_RUN:   if (!run_busy) begin pop_o = 1'b1; go_run = 1'b1; end
            K_FENCE: if (!run_busy && !copy_busy) pop_o = 1'b1;
            K_TABLE: if (!run_busy && !copy_busy) begin pop_o = 1'b1; go_table = 1'b1; end
            K_COPY:  if (!copy_busy) begin pop_o = 1'b1; go_copy = 1'b1; end
            default: begin pop_o = 1'b1; bad = 1'b1; end
          endcase
        end
        S_SETUP_ADDR: begin pop_o = 1'b1; addr_setup = 1'b1; end
        S_COPY_ADDR:  begin pop_o = 1'b1; addr_copy = 1'b1; end
        default: ;
      endcase
    end
  end

  assign ev_run_o   = run_busy && run_done_i;
  assign ev_copy_o  = copy_busy && copy_done_i;
  assign ev_bad_o   = bad;
  assign busy_o     = run_busy || copy_busy || (state != S_IDLE);
  assign run_req_o  = run_busy;
  assign copy_req_o = copy_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state         <= S_IDLE;
      run_busy      <= 1'b0;
      copy_busy     <= 1'b0;
      run_blocks_o  <= '0;
      run_addr_o    <= '0;
      copy_to_ext_o <= 1'b0;
      copy_words_o  <= '0;
      copy_addr_o   <= '0;
      tbl_load_o    <= 1'b0;
      tbl_id_o      <= '0;
      tbl_vram_o    <= 1'b0;
      tbl_sel_o     <= '0;
    end else begin
      if (go_setup)                    state <= S_SETUP_ADDR;
      else if (go_copy)                state <= S_COPY_ADDR;
      else if (addr_setup || addr_copy) state <= S_IDLE;

      if (go_run) begin
        run_busy     <= 1'b1;
        run_blocks_o <= {1'b0, head_i[CNT_W-1:0]} + (CNT_W+1)'(1);
      end else if (run_done_i) begin
        run_busy <= 1'b0;
      end

      if (addr_setup) run_addr_o <= head_i;

      if (go_copy) begin
        copy_to_ext_o <= head_i[25];
        copy_words_o  <= head_i[12 +: WC_W];
      end
      if (addr_copy) begin
        copy_addr_o <= head_i;
        copy_busy   <= 1'b1;
      end else if (copy_done_i) begin
        copy_busy <= 1'b0;
      end

      tbl_load_o <= go_table;
      if (go_table) begin
        tbl_id_o   <= head_i[20:17];
        tbl_vram_o <= head_i[23];
        tbl_sel_o  <= head_i[25:24];
      end
    end
  end
endmodule

// File: rtl/cq_status.sv
module cq_status
  import cq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ev_run_i,
  input  logic            ev_copy_i,
  input  logic            ev_bad_i,
  input  logic            ev_ovf_i,
  input  logic            reg_wr_i,
  input  logic            reg_sel_i,
  input  logic [7:0]      reg_wdata_i,
  input  logic            busy_i,
  input  logic            empty_i,
  input  logic            dma_i,
  output logic [ST_W-1:0] status_o,
  output logic            irq_o
);
  logic [7:0] sticky, en, set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[ST_RUN]   = ev_run_i;
    set_v[ST_COPY]  = ev_copy_i;
    set_v[ST_BADOP] = ev_bad_i;
    set_v[ST_OVF]   = ev_ovf_i;
    clr_v = (reg_wr_i && !reg_sel_i) ? reg_wdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky <= '0;
      en     <= '0;
    end else begin
      // a new event wins over a clear in the same cycle
      sticky <= (set_v | (sticky & ~clr_v)) & STICKY_IMPL;
      if (reg_wr_i && reg_sel_i) en <= reg_wdata_i & STICKY_IMPL;
    end
  end

  assign status_o = {dma_i, empty_i, busy_i, sticky};
  assign irq_o    = |(sticky & en);
endmodule

// File: rtl/cmdq_front.sv
module cmdq_front
  import cq_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int CNT_W = 12,
  parameter int WC_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [31:0]      cmd_data_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [ST_W-1:0]  status_o,
  output logic             irq_o,
  output logic             run_req_o,
  output logic [CNT_W:0]   run_blocks_o,
  output logic [31:0]      run_addr_o,
  input  logic             run_done_i,
  output logic             copy_req_o,
  output logic             copy_to_ext_o,
  output logic [WC_W-1:0]  copy_words_o,
  output logic [31:0]      copy_addr_o,
  input  logic             copy_done_i,
  output logic             tbl_load_o,
  output logic [3:0]       tbl_id_o,
  output logic             tbl_vram_o,
  output logic [1:0]       tbl_sel_o
);
  logic [31:0] head;
  logic        empty, drop, pop, busy, ev_run, ev_copy, ev_bad;

  cq_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (cmd_wr_i),
    .data_i (cmd_data_i),
    .pop_i  (pop),
    .head_o (head),
    .empty_o(empty),
    .drop_o (drop)
  );

  cq_sequencer #(.CNT_W(CNT_W), .WC_W(WC_W)) u_seq (
    .clk_i, .rst_ni,
    .head_i (head),
    .avail_i(!empty),
    .pop_o  (pop),
    .run_done_i, .copy_done_i,
    .run_req_o, .run_blocks_o, .run_addr_o,
    .copy_req_o, .copy_to_ext_o, .copy_words_o, .copy_addr_o,
    .tbl_load_o, .tbl_id_o, .tbl_vram_o, .tbl_sel_o,
    .busy_o   (busy),
    .ev_run_o (ev_run),
    .ev_copy_o(ev_copy),
    .ev_bad_o (ev_bad)
  );

  cq_status u_stat (
    .clk_i, .rst_ni,
    .ev_run_i (ev_run),
    .ev_copy_i(ev_copy),
    .ev_bad_i (ev_bad),
    .ev_ovf_i (drop),
    .reg_wr_i, .reg_sel_i, .reg_wdata_i,
    .busy_i   (busy),
    .empty_i  (empty),
    .dma_i    (copy_req_o),
    .status_o, .irq_o
  );
endmodule

// File: rtl/cmdq_front_checker.sv
module cmdq_front_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_wr_i,
  input logic [10:0] status_o,
  input logic        irq_o,
  input logic        run_req_o,
  input logic        run_done_i,
  input logic        copy_req_o,
  input logic [31:0] copy_addr_o,
  input logic        copy_done_i,
  input logic        tbl_load_o
);
  p_run_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_req_o && !run_done_i |=> run_req_o);

  p_copy_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_req_o && !copy_done_i |=> copy_req_o && $stable(copy_addr_o));

  p_tbl_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_load_o |-> !run_req_o && !copy_req_o);

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[5]) |-> $past(cmd_wr_i));

  p_run_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_req_o && run_done_i |=> status_o[0]);

  p_irq_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o[5:0] != 6'd0));

  p_dma_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[10] |-> status_o[8]);

  p_start_needs_word_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_req_o) |-> !$past(status_o[9]));
endmodule

bind cmdq_front cmdq_front_checker u_chk (
  .clk_i, .rst_ni, .cmd_wr_i, .status_o, .irq_o, .run_req_o, .run_done_i,
  .copy_req_o, .copy_addr_o, .copy_done_i, .tbl_load_o
);

// File: tb/cmdq_front_bench.sv
`timescale 1ns/1ps
module cmdq_front_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cmd_wr_i = 1'b0;
  logic [31:0] cmd_data_i = '0;
  logic        reg_wr_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [10:0] status_o;
  logic        irq_o;
  logic        run_req_o;
  logic [12:0] run_blocks_o;
  logic [31:0] run_addr_o;
  logic        run_done_i = 1'b0;
  logic        copy_req_o, copy_to_ext_o;
  logic [7:0]  copy_words_o;
  logic [31:0] copy_addr_o;
  logic        copy_done_i = 1'b0;
  logic        tbl_load_o, tbl_vram_o;
  logic [3:0]  tbl_id_o;
  logic [1:0]  tbl_sel_o;

  int n_run = 0, n_fail = 0, tbl_cnt = 0;
  logic [6:0] tbl_last = '0;

  always #2.5 clk_i = ~clk_i;

  cmdq_front u_cmdq_front (.*);

  always @(posedge clk_i)
    if (rst_ni && tbl_load_o) begin
      tbl_cnt++;
      tbl_last = {tbl_sel_o, tbl_vram_o, tbl_id_o};
    end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk_i); cmd_wr_i = 1'b1; cmd_data_i = w;
    @(negedge clk_i); cmd_wr_i = 1'b0;
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] d);
    @(negedge clk_i); reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i); reg_wr_i = 1'b0;
  endtask

  task automatic run_done_pulse();
    @(negedge clk_i); run_done_i = 1'b1;
    @(negedge clk_i); run_done_i = 1'b0;
  endtask

  task automatic copy_done_pulse();
    @(negedge clk_i); copy_done_i = 1'b1;
    @(negedge clk_i); copy_done_i = 1'b0;
  endtask

  function automatic logic [31:0] w_run(input logic [11:0] f);   return {6'h0E, 14'd0, f}; endfunction
  function automatic logic [31:0] w_setup();                     return {6'h10, 26'd0}; endfunction
  function automatic logic [31:0] w_fence();                     return {6'h11, 26'd0}; endfunction
  function automatic logic [31:0] w_copy(input logic d, input logic [7:0] n);
    return {6'h22, d, 5'd0, n, 12'd0};
  endfunction
  function automatic logic [31:0] w_table(input logic [1:0] s, input logic v, input logic [3:0] id);
    return {6'h15, s, v, 2'd0, id, 17'd0};
  endfunction

  task automatic t_reset();
    check("R1 status", 32'(status_o), 32'h200);
    check("R1 irq", 32'(irq_o), 0);
    check("R1 reqs", {29'd0, run_req_o, copy_req_o, tbl_load_o}, 0);
  endtask

  task automatic t_run();
    push(w_setup()); push(32'hA000_0040); push(w_run(12'd3));
    idle(1);
    check("R3 run_req", 32'(run_req_o), 1);
    check("R3 blocks", 32'(run_blocks_o), 4);
    check("R2 run_addr", run_addr_o, 32'hA000_0040);
    check("R12 busy", 32'(status_o[8]), 1);
    idle(6);
    check("R3 held", 32'(run_req_o), 1);
    check("R10 not yet", 32'(status_o[0]), 0);
    run_done_pulse();
    check("R3 released", 32'(run_req_o), 0);
    check("R10 run flag", 32'(status_o[0]), 1);
    check("R11 masked", 32'(irq_o), 0);
    push(w_run(12'd0)); idle(1);
    check("R3 one block", 32'(run_blocks_o), 1);
    run_done_pulse();
  endtask

  task automatic t_copy();
    push(w_copy(1'b1, 8'd16)); push(32'h8000_1000); idle(2);
    check("R4 req", 32'(copy_req_o), 1);
    check("R4 dir", 32'(copy_to_ext_o), 1);
    check("R4 words", 32'(copy_words_o), 16);
    check("R4 addr", copy_addr_o, 32'h8000_1000);
    check("R12 dma busy", 32'(status_o[10:8]), 32'b111);
    copy_done_pulse();
    check("R10 copy flag", 32'(status_o[1]), 1);
    check("R12 dma idle", 32'(status_o[10]), 0);
  endtask

  task automatic t_table();
    int c0 = tbl_cnt;
    push(w_table(2'd3, 1'b1, 4'hD)); idle(3);
    check("R5 one pulse", 32'(tbl_cnt - c0), 1);
    check("R5 fields", 32'(tbl_last), {25'd0, 2'd3, 1'b1, 4'hD});
    check("R5 low after", 32'(tbl_load_o), 0);
  endtask

  task automatic t_order();
    int c0 = tbl_cnt;
    push(w_copy(1'b0, 8'd4)); push(32'h1234_0000); push(w_table(2'd1, 1'b0, 4'h9));
    idle(6);
    check("R6 table waits", 32'(tbl_cnt - c0), 0);
    check("R12 queue not empty", 32'(status_o[9]), 0);
    check("R4 dir ext->ram", 32'(copy_to_ext_o), 0);
    copy_done_pulse(); idle(3);
    check("R6 table after copy", 32'(tbl_cnt - c0), 1);
    check("R6 fields", 32'(tbl_last), {25'd0, 2'd1, 1'b0, 4'h9});
  endtask

  task automatic t_fence();
    int c0 = tbl_cnt;
    push(w_run(12'd1)); push(w_fence()); push(w_table(2'd2, 1'b1, 4'h8));
    idle(6);
    check("R7 fence holds", 32'(tbl_cnt - c0), 0);
    check("R3 blocks 2", 32'(run_blocks_o), 2);
    run_done_pulse(); idle(3);
    check("R7 fence released", 32'(tbl_cnt - c0), 1);
    check("R12 queue empty", 32'(status_o[9]), 1);
  endtask

  task automatic t_bad();
    int c0 = tbl_cnt;
    reg_write(1'b0, 8'hFF);
    push(32'hFC00_0123); idle(2);
    check("R8 bad flag", 32'(status_o[7:0]), 32'h10);
    check("R8 no request", {30'd0, run_req_o, copy_req_o}, 0);
    check("R8 no table", 32'(tbl_cnt - c0), 0);
  endtask

  task automatic t_overflow();
    int c0 = tbl_cnt;
    reg_write(1'b0, 8'hFF);
    push(w_run(12'd0)); push(w_fence());
    for (int i = 0; i < 4; i++) push(w_table(2'd0, 1'b0, 4'(i)));
    check("R9 no drop yet", 32'(status_o[5]), 0);
    push(w_table(2'd3, 1'b1, 4'hF));
    check("R9 drop flag", 32'(status_o[5]), 1);
    reg_write(1'b1, 8'h20);
    check("R11 irq on ovf", 32'(irq_o), 1);
    run_done_pulse(); idle(10);
    check("R9 dropped word", 32'(tbl_cnt - c0), 4);
    check("R9 last kept", 32'(tbl_last), {25'd0, 2'd0, 1'b0, 4'h3});
  endtask

  task automatic t_irq();
    reg_write(1'b0, 8'hFF);
    check("R10 clear all", 32'(status_o[7:0]), 0);
    push(w_copy(1'b0, 8'd1)); push(32'h0); idle(2); copy_done_pulse();
    reg_write(1'b1, 8'h01);
    check("R11 other mask", 32'(irq_o), 0);
    reg_write(1'b1, 8'h33);
    check("R11 enabled", 32'(irq_o), 1);
    push(w_run(12'd0)); idle(1); run_done_pulse();
    reg_write(1'b0, 8'h02);
    check("R10 partial clear", 32'(status_o[1:0]), 1);
    check("R11 still pending", 32'(irq_o), 1);
    reg_write(1'b0, 8'h01);
    check("R11 cleared", 32'(irq_o), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3); rst_ni = 1'b1; idle(2);
    t_reset();
    t_run();
    t_copy();
    t_table();
    t_order();
    t_fence();
    t_bad();
    t_overflow();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule